// File: doc/BRIEF.md
# Release-Triggered Accumulator Calculator Core

This block is the arithmetic heart of a small push-button calculator. It keeps an 8-bit running result and combines it with a 6-bit operand whenever the user lets go of one of three function buttons: add, subtract or multiply. All arithmetic is modulo 256. A separate active-low clear input, sampled as a level, forces the result back to zero.

The button inputs are active-low: a low level means the button is held. Each button is registered once inside the block. A one-cycle pulse is formed on the cycle in which the input is seen high after it was registered low, which is the moment of release. The three pulses form a one-hot function select, ordered {add, sub, mul}, and their OR is the load enable. If two or more releases land in the same cycle, the select is not one-hot and the accumulator keeps its value. The running result and the operand are both driven out for a display subsystem. Debouncing and BCD or segment conversion are done elsewhere.

Top module: `calc_accum_core`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the accumulator output reads 0.
- R2: When the add button input rises from 0 (held) to 1 (released), the accumulator becomes (acc + operand) mod 256 at the clock edge that samples the 1.
- R3: A subtract release sets the accumulator to (acc - operand) mod 256, so results below zero wrap around (for example 4 - 8 gives 252).
- R4: A multiply release sets the accumulator to the low 8 bits of acc * operand.
- R5: Only a release acts. Pressing a button, holding it low or leaving it high causes no change to the accumulator.
- R6: If releases of two or more buttons fall on the same clock edge, the accumulator keeps its value.
- R7: A low level on the clear input zeroes the accumulator at the next clock edge and overrides any release on that edge.
- R8: The operand output always equals the operand input.
- R9: On every edge with no release and no clear, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| clear_ni | input | 1 | Active-low level-sensitive clear of the accumulator |
| add_ni | input | 1 | Add button, 0 = held |
| sub_ni | input | 1 | Subtract button, 0 = held |
| mul_ni | input | 1 | Multiply button, 0 = held |
| operand_i | input | 6 | Operand applied by the next operation |
| operand_o | output | 6 | Operand passed through for display |
| acc_o | output | 8 | Current accumulator value |

## Verification
On every cycle, the assertions check the arithmetic result of each single release, the zeroing after clear, the hold on cycles with no operation or with colliding releases, and that a pulse only ever follows a registered low and a current high on its button. These checks tie the internal function select to the ports. They cannot show that a button held for many cycles gives exactly one operation, or that a long chain of mixed operations with wrap-around ends at the right value. The bench's scenarios cover those cases, using a behavioural reference model that is compared against the outputs on every clock.

// File: rtl/calc_pkg.sv
package calc_pkg;

  localparam int unsigned NUM_BTN = 3;

  // Button index inside the internal pulse vector; the function select
  // is ordered {add, sub, mul}, so these indices are also its bit positions.
  localparam int unsigned BTN_MUL = 0;
  localparam int unsigned BTN_SUB = 1;
  localparam int unsigned BTN_ADD = 2;

  localparam logic [NUM_BTN-1:0] FN_NONE = 3'b000;
  localparam logic [NUM_BTN-1:0] FN_MUL  = 3'b001;
  localparam logic [NUM_BTN-1:0] FN_SUB  = 3'b010;
  localparam logic [NUM_BTN-1:0] FN_ADD  = 3'b100;

endpackage

// File: rtl/calc_release_pulse.sv
module calc_release_pulse #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] btn_ni,
  output logic [N-1:0] pulse_o
);

  logic [N-1:0] btn_q;
  logic [N-1:0] btn_d;

  for (genvar g = 0; g < N; g++) begin : g_btn
    // next state: always follow the raw input
    always_comb begin
      btn_d[g] = btn_ni[g];
    end

    // released level on reset, so no pulse right after reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        btn_q[g] <= 1'b1;
      end else begin
        btn_q[g] <= btn_d[g];
      end
    end

    // high now, low one cycle ago: the button has just been released
    assign pulse_o[g] = btn_ni[g] & ~btn_q[g];
  end

endmodule

// File: rtl/calc_func_decode.sv
module calc_func_decode
  import calc_pkg::*;
(
  input  logic [NUM_BTN-1:0] pulse_i,
  output logic [NUM_BTN-1:0] func_sel_o,
  output logic               load_en_o,
  output logic               single_o
);

  always_comb begin
    func_sel_o = {pulse_i[BTN_ADD], pulse_i[BTN_SUB], pulse_i[BTN_MUL]};
    load_en_o  = |pulse_i;
    // at most one bit set: clearing the lowest set bit leaves zero
    single_o   = ((func_sel_o & (func_sel_o - 1'b1)) == '0);
  end

endmodule

// File: rtl/calc_accum_reg.sv
module calc_accum_reg
  import calc_pkg::*;
#(
  parameter int unsigned ACCW = 8,
  parameter int unsigned OPW  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               load_en_i,
  input  logic               single_i,
  input  logic [NUM_BTN-1:0] func_sel_i,
  input  logic [OPW-1:0]     operand_i,
  output logic [ACCW-1:0]    acc_o
);

  localparam int unsigned PRODW = ACCW + OPW;

  logic [ACCW-1:0]  acc_q;
  logic [ACCW-1:0]  acc_d;
  logic [ACCW-1:0]  op_ext;
  logic [PRODW-1:0] prod;
  logic             acc_en;

  always_comb begin
    op_ext = ACCW'(operand_i);
    prod   = PRODW'(acc_q) * PRODW'(operand_i);
    acc_en = clear_i | (load_en_i & single_i);
    acc_d  = acc_q;
    if (clear_i) begin
      acc_d = '0;
    end else begin
      unique case (func_sel_i)
        FN_ADD:  acc_d = acc_q + op_ext;
        FN_SUB:  acc_d = acc_q - op_ext;
        FN_MUL:  acc_d = prod[ACCW-1:0];
        default: acc_d = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/calc_accum_core.sv
module calc_accum_core
  import calc_pkg::*;
#(
  parameter int unsigned ACCW = 8,
  parameter int unsigned OPW  = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_ni,
  input  logic            add_ni,
  input  logic            sub_ni,
  input  logic            mul_ni,
  input  logic [OPW-1:0]  operand_i,
  output logic [OPW-1:0]  operand_o,
  output logic [ACCW-1:0] acc_o
);

  logic [NUM_BTN-1:0] btn_n;
  logic [NUM_BTN-1:0] pulse;
  logic [NUM_BTN-1:0] func_sel;
  logic               load_en;
  logic               single;

  always_comb begin
    btn_n          = '1;
    btn_n[BTN_ADD] = add_ni;
    btn_n[BTN_SUB] = sub_ni;
    btn_n[BTN_MUL] = mul_ni;
  end

  calc_release_pulse #(
    .N(NUM_BTN)
  ) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_ni (btn_n),
    .pulse_o(pulse)
  );

  calc_func_decode u_decode (
    .pulse_i   (pulse),
    .func_sel_o(func_sel),
    .load_en_o (load_en),
    .single_o  (single)
  );

  calc_accum_reg #(
    .ACCW(ACCW),
    .OPW (OPW)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (~clear_ni),
    .load_en_i (load_en),
    .single_i  (single),
    .func_sel_i(func_sel),
    .operand_i (operand_i),
    .acc_o     (acc_o)
  );

  assign operand_o = operand_i;

endmodule

// File: rtl/calc_accum_core_chk.sv
module calc_accum_core_chk #(
  parameter int unsigned ACCW = 8,
  parameter int unsigned OPW  = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clear_ni,
  input logic            add_ni,
  input logic            sub_ni,
  input logic            mul_ni,
  input logic [OPW-1:0]  operand_i,
  input logic [OPW-1:0]  operand_o,
  input logic [ACCW-1:0] acc_o,
  input logic [2:0]      func_sel,
  input logic            load_en
);

  logic [ACCW-1:0]      op_ext;
  logic [ACCW+OPW-1:0]  prod_full;
  logic [ACCW-1:0]      sum_w, diff_w, prod_w;

  always_comb begin
    op_ext    = ACCW'(operand_i);
    prod_full = (ACCW+OPW)'(acc_o) * (ACCW+OPW)'(operand_i);
    sum_w     = acc_o + op_ext;
    diff_w    = acc_o - op_ext;
    prod_w    = prod_full[ACCW-1:0];
  end

  // R8: pass-through of the operand
  always_comb begin
    a_operand_pass_r8: assert (operand_o == operand_i);
  end

  p_add_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && func_sel == 3'b100) |=> (acc_o == $past(sum_w)));

  p_sub_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && func_sel == 3'b010) |=> (acc_o == $past(diff_w)));

  p_mul_trunc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && func_sel == 3'b001) |=> (acc_o == $past(prod_w)));

  p_add_on_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_sel[2] |-> (add_ni && !$past(add_ni)));

  p_sub_on_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_sel[1] |-> (sub_ni && !$past(sub_ni)));

  p_mul_on_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_sel[0] |-> (mul_ni && !$past(mul_ni)));

  p_multi_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && $countones(func_sel) > 1) |=> $stable(acc_o));

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_ni |=> (acc_o == '0));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && !load_en) |=> $stable(acc_o));

endmodule

bind calc_accum_core calc_accum_core_chk #(
  .ACCW(ACCW),
  .OPW (OPW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clear_ni (clear_ni),
  .add_ni   (add_ni),
  .sub_ni   (sub_ni),
  .mul_ni   (mul_ni),
  .operand_i(operand_i),
  .operand_o(operand_o),
  .acc_o    (acc_o),
  .func_sel (func_sel),
  .load_en  (load_en)
);

// File: tb/calc_accum_core_tb_top.sv
module calc_accum_core_tb_top;

  logic       clk;
  logic       rst_n;
  logic       clear_n;
  logic       add_n, sub_n, mul_n;
  logic [5:0] operand;
  logic [5:0] operand_out;
  logic [7:0] acc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string cur_req = "R9";

  // reference model state
  int m_acc;
  bit m_pa, m_ps, m_pm;

  calc_accum_core dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .clear_ni (clear_n),
    .add_ni   (add_n),
    .sub_ni   (sub_n),
    .mul_ni   (mul_n),
    .operand_i(operand),
    .operand_o(operand_out),
    .acc_o    (acc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // behavioural reference: integers, modulo arithmetic
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0;
      m_pa = 1; m_ps = 1; m_pm = 1;
    end else begin
      automatic bit ra = add_n && !m_pa;
      automatic bit rs = sub_n && !m_ps;
      automatic bit rm = mul_n && !m_pm;
      automatic int cnt = int'(ra) + int'(rs) + int'(rm);
      if (!clear_n) m_acc = 0;
      else if (cnt == 1) begin
        if (ra) m_acc = (m_acc + int'(operand)) % 256;
        else if (rs) m_acc = (m_acc - int'(operand) + 256) % 256;
        else m_acc = (m_acc * int'(operand)) % 256;
      end
      m_pa = add_n; m_ps = sub_n; m_pm = mul_n;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) check(cur_req, int'(acc), m_acc);
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // press a button for two cycles then release; returns at the negedge
  // after the edge that sampled the release
  task automatic op(int which, int opnd);
    @(negedge clk);
    operand = 6'(opnd);
    if (which == 0) add_n = 0; else if (which == 1) sub_n = 0; else mul_n = 0;
    @(negedge clk);
    @(negedge clk);
    add_n = 1; sub_n = 1; mul_n = 1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; clear_n = 1; add_n = 1; sub_n = 1; mul_n = 1; operand = '0;
    repeat (3) @(negedge clk);
    check("R1", int'(acc), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(acc), 0);

    cur_req = "R2";
    op(0, 5);            check("R2", int'(acc), 5);
    op(0, 63);           check("R2", int'(acc), 68);
    operand = 6'd17; #1; check("R8", int'(operand_out), 17);

    cur_req = "R4";
    op(2, 4);            check("R4", int'(acc), 16);   // 272 mod 256
    op(2, 63);           check("R4", int'(acc), 240);  // 1008 mod 256

    cur_req = "R3";
    op(1, 40);           check("R3", int'(acc), 200);
    op(2, 0);            check("R4", int'(acc), 0);
    op(0, 4);            check("R2", int'(acc), 4);
    op(1, 8);            check("R3", int'(acc), 252);  // wrap below zero

    // R5: long hold does nothing until release; exactly one add after
    cur_req = "R5";
    @(negedge clk); operand = 6'd3; add_n = 0;
    repeat (6) @(negedge clk);
    check("R5", int'(acc), 252);
    add_n = 1;
    @(negedge clk);      check("R5", int'(acc), 255);
    repeat (4) @(negedge clk);
    check("R5", int'(acc), 255);

    // R6: simultaneous release of add and sub
    cur_req = "R6";
    add_n = 0; sub_n = 0; operand = 6'd9;
    repeat (2) @(negedge clk);
    add_n = 1; sub_n = 1;
    @(negedge clk);      check("R6", int'(acc), 255);
    mul_n = 0; add_n = 0; sub_n = 0;
    repeat (2) @(negedge clk);
    mul_n = 1; add_n = 1; sub_n = 1;
    @(negedge clk);      check("R6", int'(acc), 255);

    // R7: clear overrides a release on the same edge
    cur_req = "R7";
    add_n = 0; operand = 6'd10;
    repeat (2) @(negedge clk);
    add_n = 1; clear_n = 0;
    @(negedge clk);      check("R7", int'(acc), 0);
    clear_n = 1;
    op(0, 10);           check("R7", int'(acc), 10);
    clear_n = 0;
    @(negedge clk);      check("R7", int'(acc), 0);
    clear_n = 1;

    // R9: idle cycles with changing operand hold the value
    cur_req = "R9";
    op(0, 33);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); operand = 6'(i * 7);
    end
    @(negedge clk);      check("R9", int'(acc), 33);

    // mixed sequence against the model
    cur_req = "R2";
    for (int i = 0; i < 30; i++) op(i % 3, (i * 13 + 5) % 64);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule